// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial bus placed in front of a 128-entry, 8-bit memory. It runs on a fast system clock and oversamples the bus clock and data lines. Each line passes through a two-flop synchronizer and then a short stability filter. From the filtered lines the block finds bus clock edges and the start and stop conditions. It then walks a bit-level transfer state machine.

A transfer opens with a start condition. The single byte that follows holds the 7-bit word address, sent most significant bit first, and a read/write flag in the last bit. No device-select byte exists.

Write bytes go to an external page-write engine together with their target address. When a stop ends a write transaction, the block raises a commit pulse. While the engine reports busy, the block does not acknowledge an address byte and keeps the data line released.

Reads take data from a combinational array read port, addressed by the block's own address counter. The bus data line is open drain. The block only ever asserts an enable that pulls it low.

Top module: `tw_mem_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start condition and a rising SDA while SCL is high is a stop condition. A stop returns the block to idle from any state with SDA released. `sda_oe` changes only while the filtered SCL is low.
- R2: Before the first start condition, bus activity produces no acknowledge and no write strobe.
- R3: The first byte after a start is a 7-bit word address, MSB first, followed by a read/write bit in which 1 means read. The block acknowledges this byte by pulling SDA low during the ninth SCL pulse.
- R4: In a write, each received data byte is acknowledged on its ninth pulse. Each data byte also produces a one-cycle `wr_valid_o` carrying `wr_addr_o` and `wr_data_o`.
- R5: Between write bytes only the low 2 address bits advance, wrapping within the 4-byte page, and the upper 5 bits stay fixed.
- R6: A stop that ends a transaction in which at least one data byte was written produces exactly one `wr_commit_o` pulse. A transaction with no data byte produces none.
- R7: In a read, the block sends the byte at the current address, MSB first. It then releases SDA for the ninth pulse.
- R8: If SDA is low on the ninth pulse of a read, the master has acknowledged and the next byte follows. If SDA is high, the block drives nothing further until the next start or stop.
- R9: The read address advances across all 7 bits after each byte and wraps from 127 to 0.
- R10: While `wr_busy_i` is high when an address byte completes, the block gives no acknowledge and leaves SDA released until the next start or stop.
- R11: A start in the middle of a transfer restarts address reception.
- R12: `sda_oe` is low after reset. The block never drives SDA high; it only enables a pull-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull-down enable for the open-drain data pad |
| wr_busy_i | input | 1 | Page-write engine is busy with an internal write |
| wr_valid_o | output | 1 | One-cycle strobe for a received write byte |
| wr_addr_o | output | 7 | Target address of the write byte |
| wr_data_o | output | 8 | Write byte |
| wr_commit_o | output | 1 | One-cycle pulse: write transaction closed by stop |
| rd_addr_o | output | 7 | Array read address |
| rd_data_i | input | 8 | Array read data for `rd_addr_o` |

## Verification
A wrong bit count or a wrong state shows up at the next ninth SCL pulse. In that case the master sees a missing acknowledge, or a pull-down where data should appear, within one byte time. A faulty address counter does not fail on the bus by itself. It appears as a wrong read-back value or a wrong `wr_addr_o`. For that reason every write is read back through the bus, and the sequential reads cross both a page boundary and the top of the array. Busy handling and the not-acknowledge path are seen on the very first ninth pulse after the condition, as an SDA level that stays high.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_WDATA,
        ST_ACK_W,
        ST_RDATA,
        ST_RACK,
        ST_HOLD
    } tw_state_e;
endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic line_o
);
    localparam int CW = (FILT > 1) ? $clog2(FILT + 1) : 1;

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          line;
    } filt_t;

    filt_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        r_d.sync = {r_q.sync[0], raw_i};
        if (r_q.sync[1] == r_q.line) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == CW'(FILT - 1)) begin
            r_d.cnt  = '0;
            r_d.line = r_q.sync[1];
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sync <= 2'b11;
            r_q.cnt  <= '0;
            r_q.line <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign line_o = r_q.line;

    // R1: a filtered level only flips after the synchronized input disagreed with it
    assert_filter_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.line) |-> (r_q.line == $past(r_q.sync[1])));
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic cond_start,
    output logic cond_stop
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t p_q, p_d;

    always_comb begin
        p_d.scl = scl_f;
        p_d.sda = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            p_q <= p_d;
        end
    end

    assign scl_rise   = scl_f & ~p_q.scl;
    assign scl_fall   = ~scl_f & p_q.scl;
    assign cond_start = scl_f & p_q.scl & p_q.sda & ~sda_f;
    assign cond_stop  = scl_f & p_q.scl & ~p_q.sda & sda_f;
endmodule

// File: rtl/tw_addr_unit.sv
module tw_addr_unit #(
    parameter int AW = 7,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          inc_page_i,
    input  logic          inc_full_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] addr_q, addr_d;

    always_comb begin
        addr_d = addr_q;
        if (load_i) begin
            addr_d = load_val_i;
        end else if (inc_full_i) begin
            addr_d = addr_q + 1'b1;
        end else if (inc_page_i) begin
            addr_d = {addr_q[AW-1:PW], addr_q[PW-1:0] + 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_o = addr_q;

    // R5: page stepping never disturbs the page number
    assert_page_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_page_i && !load_i && !inc_full_i) |=> (addr_q[AW-1:PW] == $past(addr_q[AW-1:PW])));

    // R9: full stepping from the top of the array lands on zero
    assert_full_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_full_i && !load_i && (addr_q == {AW{1'b1}})) |=> (addr_q == '0));
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave #(
    parameter int AW   = 7,
    parameter int DW   = 8,
    parameter int PW   = 2,
    parameter int FILT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic          wr_busy_i,
    output logic          wr_valid_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          wr_commit_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic [DW-1:0] rd_data_i
);
    import tw_pkg::*;

    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] BYTE_DONE = CW'(DW);
    localparam logic [CW-1:0] LAST_TX   = CW'(DW - 1);

    logic [1:0] raw_lines, filt_lines;
    logic scl_f, sda_f;
    logic scl_rise, scl_fall, ev_start, ev_stop;
    logic addr_ld, addr_inc_pg, addr_inc_all;
    logic [AW-1:0] cur_addr;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        tw_line_filter #(.FILT(FILT)) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    tw_bus_events evt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f      (scl_f),
        .sda_f      (sda_f),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .cond_start (ev_start),
        .cond_stop  (ev_stop)
    );

    typedef struct packed {
        tw_state_e     state;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sh;
        logic [DW-1:0] tx;
        logic          rd;
        logic          oe;
        logic          mack;
        logic          pend;
        logic          wv;
        logic [DW-1:0] wd;
        logic          commit;
    } ctl_t;

    ctl_t c_q, c_d;

    always_comb begin
        c_d          = c_q;
        c_d.wv       = 1'b0;
        c_d.commit   = 1'b0;
        addr_ld      = 1'b0;
        addr_inc_pg  = 1'b0;
        addr_inc_all = 1'b0;

        if (ev_stop) begin
            c_d.state  = ST_IDLE;
            c_d.oe     = 1'b0;
            c_d.commit = c_q.pend;
            c_d.pend   = 1'b0;
        end else if (ev_start) begin
            c_d.state = ST_ADDR;
            c_d.cnt   = '0;
            c_d.oe    = 1'b0;
        end else begin
            unique case (c_q.state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        c_d.sh  = {c_q.sh[DW-2:0], sda_f};
                        c_d.cnt = c_q.cnt + 1'b1;
                    end else if (scl_fall && c_q.cnt == BYTE_DONE) begin
                        if (wr_busy_i) begin
                            c_d.state = ST_HOLD;
                        end else begin
                            c_d.oe    = 1'b1;
                            c_d.rd    = c_q.sh[0];
                            addr_ld   = 1'b1;
                            c_d.state = ST_ACK_ADDR;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (scl_fall) begin
                        c_d.cnt = '0;
                        if (c_q.rd) begin
                            c_d.tx    = rd_data_i;
                            c_d.oe    = ~rd_data_i[DW-1];
                            c_d.state = ST_RDATA;
                        end else begin
                            c_d.oe    = 1'b0;
                            c_d.state = ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        c_d.sh  = {c_q.sh[DW-2:0], sda_f};
                        c_d.cnt = c_q.cnt + 1'b1;
                    end else if (scl_fall && c_q.cnt == BYTE_DONE) begin
                        c_d.oe    = 1'b1;
                        c_d.wv    = 1'b1;
                        c_d.wd    = c_q.sh;
                        c_d.pend  = 1'b1;
                        c_d.state = ST_ACK_W;
                    end
                end
                ST_ACK_W: begin
                    if (scl_fall) begin
                        c_d.oe      = 1'b0;
                        c_d.cnt     = '0;
                        addr_inc_pg = 1'b1;
                        c_d.state   = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (c_q.cnt == LAST_TX) begin
                            c_d.oe       = 1'b0;
                            addr_inc_all = 1'b1;
                            c_d.state    = ST_RACK;
                        end else begin
                            c_d.cnt = c_q.cnt + 1'b1;
                            c_d.tx  = {c_q.tx[DW-2:0], 1'b0};
                            c_d.oe  = ~c_q.tx[DW-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        c_d.mack = ~sda_f;
                    end else if (scl_fall) begin
                        if (c_q.mack) begin
                            c_d.cnt   = '0;
                            c_d.tx    = rd_data_i;
                            c_d.oe    = ~rd_data_i[DW-1];
                            c_d.state = ST_RDATA;
                        end else begin
                            c_d.state = ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: ST_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    tw_addr_unit #(.AW(AW), .PW(PW)) addr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (addr_ld),
        .load_val_i (c_q.sh[DW-1:1]),
        .inc_page_i (addr_inc_pg),
        .inc_full_i (addr_inc_all),
        .addr_o     (cur_addr)
    );

    assign sda_oe      = c_q.oe;
    assign wr_valid_o  = c_q.wv;
    assign wr_data_o   = c_q.wd;
    assign wr_addr_o   = cur_addr;
    assign wr_commit_o = c_q.commit;
    assign rd_addr_o   = cur_addr;

    // R2: nothing is driven while idle
    assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_IDLE) |-> (!sda_oe && !wr_valid_o));

    // R1, R12: the pull-down only moves while the bus clock is low
    assert_oe_moves_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    // R10: an address acknowledge is never entered while the engine is busy
    assert_no_ack_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.state == ST_ACK_ADDR) && ($past(c_q.state) == ST_ADDR)) |-> !$past(wr_busy_i));

    // R4: a write strobe appears only with the data acknowledge
    assert_strobe_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> (sda_oe && c_q.state == ST_ACK_W));
endmodule

// File: tb/tw_mem_slave_tb_top.sv
module tw_mem_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 20;
    localparam int BUSY_CYC   = 1500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic sda_oe, wr_valid, wr_commit;
    logic [6:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic bus_sda;

    logic [7:0] mem [128];
    logic [7:0] exp_mem [128];

    int total = 0;
    int bad = 0;
    int n_wv = 0;
    int n_commit = 0;
    int busy_left = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_sda = sda_m & ~sda_oe;
    assign rd_data = mem[rd_addr];

    tw_mem_slave dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (bus_sda),
        .sda_oe      (sda_oe),
        .wr_busy_i   (busy),
        .wr_valid_o  (wr_valid),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .wr_commit_o (wr_commit),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data)
    );

    // page-write engine model: stores bytes, busy after commit
    always @(posedge clk) begin
        if (wr_valid) begin
            mem[wr_addr] <= wr_data;
            n_wv <= n_wv + 1;
        end
        if (wr_commit) begin
            n_commit  <= n_commit + 1;
            busy_left <= BUSY_CYC;
            busy      <= 1'b1;
        end else if (busy_left > 0) begin
            busy_left <= busy_left - 1;
            if (busy_left == 1) busy <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        wt(HP/2); sda_m = b; wt(HP/2);
        scl_m = 1'b1; wt(HP); scl_m = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        wt(HP/2); sda_m = 1'b1; wt(HP/2);
        scl_m = 1'b1; wt(HP/2); b = bus_sda; wt(HP/2); scl_m = 1'b0;
    endtask

    task automatic do_start();
        wt(HP/2); sda_m = 1'b1; wt(HP/2);
        scl_m = 1'b1; wt(HP); sda_m = 1'b0; wt(HP); scl_m = 1'b0;
    endtask

    task automatic do_stop();
        wt(HP/2); sda_m = 1'b0; wt(HP/2);
        scl_m = 1'b1; wt(HP); sda_m = 1'b1; wt(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        acked = ~a;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            bit_in(x);
            d[i] = x;
        end
        bit_out(~give_ack);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        wt(4);
    endtask

    // write/read-back vectors: {addr[6:0], data[7:0]}
    localparam logic [14:0] VEC [6] = '{
        {7'h00, 8'hA5}, {7'h7F, 8'h3C}, {7'h15, 8'hFF},
        {7'h42, 8'h00}, {7'h2A, 8'h81}, {7'h63, 8'h7E}
    };

    initial begin
        logic ack;
        logic [7:0] d;
        int wv0, cm0;
        for (int i = 0; i < 128; i++) begin
            mem[i]     = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        wt(5);
        chk("R12 reset sda_oe", 32'(sda_oe), 0);
        chk("R12 reset wr_valid", 32'(wr_valid), 0);
        rst_n = 1'b1;
        wt(10);
        scl_m = 1'b0;

        // R2: a byte clocked without a start gets no acknowledge and no strobe
        wv0 = n_wv;
        send_byte({7'h10, 1'b0}, ack);
        chk("R2 no ack before start", 32'(ack), 0);
        send_byte(8'hC3, ack);
        chk("R2 no strobe before start", 32'(n_wv - wv0), 0);
        do_stop();

        // table: byte write then byte read back (R3, R4, R6, R7)
        for (int v = 0; v < 6; v++) begin
            logic [6:0] a;
            logic [7:0] dv;
            a  = VEC[v][14:8];
            dv = VEC[v][7:0];
            cm0 = n_commit;
            do_start();
            send_byte({a, 1'b0}, ack);
            chk("R3 write address ack", 32'(ack), 1);
            send_byte(dv, ack);
            chk("R4 data ack", 32'(ack), 1);
            do_stop();
            wt(2);
            exp_mem[a] = dv;
            chk("R6 one commit", 32'(n_commit - cm0), 1);
            wait_idle();
            do_start();
            send_byte({a, 1'b1}, ack);
            chk("R3 read address ack", 32'(ack), 1);
            read_byte(1'b0, d);
            chk("R7 read back", 32'(d), 32'(exp_mem[a]));
            do_stop();
        end

        // R5: five bytes into page 0x20 starting at 0x21 wrap inside the page
        do_start();
        send_byte({7'h21, 1'b0}, ack);
        for (int k = 0; k < 5; k++) begin
            logic [6:0] pa;
            pa = {5'(7'h21 >> 2), 2'(2'd1 + 2'(k))};
            send_byte(8'hB0 + 8'(k), ack);
            chk("R4 page byte ack", 32'(ack), 1);
            exp_mem[pa] = 8'hB0 + 8'(k);
        end
        do_stop();
        wait_idle();
        do_start();
        send_byte({7'h20, 1'b1}, ack);
        for (int k = 0; k < 5; k++) begin
            read_byte(k != 4, d);
            chk("R5 page wrap contents", 32'(d), 32'(exp_mem[7'h20 + 7'(k)]));
        end
        do_stop();

        // R9: sequential read across the top of the array
        do_start();
        send_byte({7'h7E, 1'b1}, ack);
        for (int k = 0; k < 4; k++) begin
            read_byte(k != 3, d);
            chk("R9 sequential wrap", 32'(d), 32'(exp_mem[7'(7'h7E + 7'(k))]));
        end
        do_stop();

        // R8: not-acknowledge ends transmission; next clocks see a released line
        do_start();
        send_byte({7'h05, 1'b1}, ack);
        read_byte(1'b0, d);
        chk("R7 byte before nack", 32'(d), 32'(exp_mem[7'h05]));
        read_byte(1'b0, d);
        chk("R8 line released after nack", 32'(d), 32'hFF);
        do_stop();
        chk("R1 stop releases", 32'(sda_oe), 0);

        // R6: an address-only write transaction commits nothing
        cm0 = n_commit;
        do_start();
        send_byte({7'h11, 1'b0}, ack);
        do_stop();
        wt(4);
        chk("R6 no commit without data", 32'(n_commit - cm0), 0);

        // R10: busy engine -> no address acknowledge, then polling succeeds
        do_start();
        send_byte({7'h33, 1'b0}, ack);
        send_byte(8'h99, ack);
        do_stop();
        exp_mem[7'h33] = 8'h99;
        wt(4);
        chk("R10 engine busy", 32'(busy), 1);
        wv0 = n_wv;
        do_start();
        send_byte({7'h33, 1'b1}, ack);
        chk("R10 no ack while busy", 32'(ack), 0);
        send_byte(8'h00, ack);
        chk("R10 line released while busy", 32'(ack), 0);
        chk("R10 no strobe while busy", 32'(n_wv - wv0), 0);
        do_stop();
        wait_idle();
        do_start();
        send_byte({7'h33, 1'b1}, ack);
        chk("R10 ack after busy", 32'(ack), 1);
        read_byte(1'b0, d);
        chk("R10 data after busy", 32'(d), 32'h99);
        do_stop();

        // R11: repeated start after a write address re-targets a read
        do_start();
        send_byte({7'h10, 1'b0}, ack);
        chk("R11 first address ack", 32'(ack), 1);
        do_start();
        send_byte({7'h30, 1'b1}, ack);
        chk("R11 restarted address ack", 32'(ack), 1);
        read_byte(1'b0, d);
        chk("R11 read after repeated start", 32'(d), 32'(exp_mem[7'h30]));
        do_stop();

        wt(10);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule